// File: doc/BRIEF.md
# Slow-Control Register Request Decoder

This block takes one slow-control request at a time as a stream of 32-bit words, with the transport headers already removed. It checks the four-word header, runs the requested register accesses on a simple synchronous register bus, and sends the reply as a stream of 32-bit words. The header holds the request ID, a location word, a command word and an info word.

Four access modes are supported:

- paired address/data writes;
- burst writes to consecutive addresses;
- burst reads, with one read for each dummy payload word;
- reads of an explicit list of addresses.

Every access adds an error word and a data word to the reply. A request that fails a header check is dropped and causes no register access. If enabled, the block answers a dropped request with a single word that carries the error flags.

The input is accepted under `in_ready_o`, because one input word can give rise to two reply words. The reply stream has no backpressure.

Top module: `sc_req_decoder`

## Requirements
- R1: After reset, `out_valid_o`, `reg_we_o` and `reg_re_o` are low and `in_ready_o` is high.
- R2: The reply to an accepted request starts with four words, the first flagged with `out_sof_o`. These are the request ID with bit 31 cleared, then the location word, the command word and the info word, each copied unchanged.
- R3: A command word with bits 31:24 = 0xAA and bits 23:16 = 0xAA selects paired writes. Payload words alternate address and data, and each complete pair writes its data word to its address.
- R4: Bits 31:24 = 0xAA with bits 23:16 = 0xBB selects burst write. Payload word k is written to the address in the info word plus k, taken modulo 2^AddrW.
- R5: Bits 31:24 = 0xBB with bits 23:16 = 0xBB selects burst read. One register is read per payload word, starting at the info-word address and stepping by one modulo 2^AddrW.
- R6: Bits 31:24 = 0xBB with bits 23:16 = 0xAA selects list read. Each payload word, truncated to AddrW bits, is an address that is read once.
- R7: Each access adds two reply words in order: the bus error code, then the data word. The data word is the value written for a write and the value read for a read. The last reply word carries `out_eof_o`. A request with no payload puts `out_eof_o` on the fourth header word. `in_ready_o` is low whenever a reply word is being sent.
- R8: A strobe lasts exactly one cycle, and the read and write strobes are never high together. `reg_rdata_i` and `reg_err_i` are sampled in the cycle after the strobe. The number of strobes for a request equals the number of accesses in it.
- R9: A request whose bit 31 of word 0 is clear gets error bit 26, is dropped and causes no access.
- R10: A request that ends before its fourth word gets error bit 27 and is dropped.
- R11: A command byte pair outside {0xAA, 0xBB} x {0xAA, 0xBB} gets error bit 19. A command word whose bits 15:0 are not 0xFFFF gets error bit 18. Either one drops the request.
- R12: For a dropped request with `err_reply_en_i` high, the block emits one word flagged with both `out_sof_o` and `out_eof_o`, holding the OR of the detected error bits, in the cycle after the last input word is accepted. With `err_reply_en_i` low it emits nothing.
- R13: In paired-write mode, a payload that ends on an unpaired address word performs no access for that word. The open reply is then closed by one word with only bit 18 set, flagged `out_eof_o` and not `out_sof_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| err_reply_en_i | input | 1 | Enables the single-word answer to dropped requests |
| in_valid_i | input | 1 | Input word valid |
| in_sof_i | input | 1 | First word of a request |
| in_eof_i | input | 1 | Last word of a request |
| in_data_i | input | 32 | Input word |
| in_ready_o | output | 1 | Input word accepted when high together with valid |
| reg_addr_o | output | AddrW | Register address |
| reg_wdata_o | output | 32 | Register write data |
| reg_we_o | output | 1 | Write strobe |
| reg_re_o | output | 1 | Read strobe |
| reg_rdata_i | input | 32 | Read data, valid the cycle after the read strobe |
| reg_err_i | input | 32 | Access error code, valid the cycle after any strobe |
| out_valid_o | output | 1 | Reply word valid |
| out_sof_o | output | 1 | First word of a reply |
| out_eof_o | output | 1 | Last word of a reply |
| out_data_o | output | 32 | Reply word |

## Verification
The bench builds the decoder with AddrW = 4, which gives a register space of sixteen entries. A burst of a few words then runs past the top address and wraps to zero, which exercises the modulo stepping of R4 and R5. Random paired writes and list reads also hit the same registers often, so a later read returns data that an earlier request wrote. Random gaps in the input stream make the header and payload counters hold their state across idle cycles.

// File: rtl/sc_pkg.sv
package sc_pkg;
  typedef enum logic [1:0] {MODE_PAIRS, MODE_BWR, MODE_BRD, MODE_LIST} sc_mode_e;
  typedef enum logic [2:0] {
    ST_HDR, ST_HOLD, ST_ECHO, ST_PAY, ST_STRB, ST_ERRW, ST_DATW, ST_FAIL
  } sc_state_e;

  localparam logic [7:0]  OP_A    = 8'hAA;
  localparam logic [7:0]  OP_B    = 8'hBB;
  localparam logic [15:0] LEN_RSV = 16'hFFFF;

  localparam int ERR_SHORT     = 27;
  localparam int ERR_ID        = 26;
  localparam int ERR_UNKNOWN   = 19;
  localparam int ERR_MALFORMED = 18;
endpackage

// File: rtl/sc_cmd_decode.sv
module sc_cmd_decode
  import sc_pkg::*;
(
  input  logic [31:0] word_i,
  output sc_mode_e    mode_o,
  output logic        unknown_o,
  output logic        malformed_o
);
  logic [7:0] op, ty;
  assign op = word_i[31:24];
  assign ty = word_i[23:16];

  always_comb begin
    unknown_o   = !(((op == OP_A) || (op == OP_B)) && ((ty == OP_A) || (ty == OP_B)));
    malformed_o = (word_i[15:0] != LEN_RSV);
    unique case ({op == OP_B, ty == OP_B})
      2'b00:   mode_o = MODE_PAIRS;
      2'b01:   mode_o = MODE_BWR;
      2'b11:   mode_o = MODE_BRD;
      default: mode_o = MODE_LIST;
    endcase
  end
endmodule

// File: rtl/sc_addr_gen.sv
module sc_addr_gen #(
  parameter int AddrW = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [AddrW-1:0] load_val_i,
  input  logic             step_i,
  output logic [AddrW-1:0] addr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     addr_o <= '0;
    else if (load_i) addr_o <= load_val_i;
    else if (step_i) addr_o <= addr_o + 1'b1;
  end

  // R4/R5: burst address advances by one and wraps at the top
  a_r4_addr_wraps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i) |=> (addr_o == AddrW'($past(addr_o) + 1'b1)));
endmodule

// File: rtl/sc_req_decoder.sv
module sc_req_decoder
  import sc_pkg::*;
#(
  parameter int AddrW = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             err_reply_en_i,
  input  logic             in_valid_i,
  input  logic             in_sof_i,
  input  logic             in_eof_i,
  input  logic [31:0]      in_data_i,
  output logic             in_ready_o,
  output logic [AddrW-1:0] reg_addr_o,
  output logic [31:0]      reg_wdata_o,
  output logic             reg_we_o,
  output logic             reg_re_o,
  input  logic [31:0]      reg_rdata_i,
  input  logic [31:0]      reg_err_i,
  output logic             out_valid_o,
  output logic             out_sof_o,
  output logic             out_eof_o,
  output logic [31:0]      out_data_o
);
  localparam int HdrWords = 4;
  localparam int IdxW     = $clog2(HdrWords);
  localparam logic [IdxW-1:0] IdxLast = IdxW'(HdrWords - 1);
  localparam logic [IdxW-1:0] IdxCmd  = IdxW'(2);

  sc_state_e              state_q;
  logic [HdrWords-1:0][31:0] hdr_q;
  logic [IdxW-1:0]        idx_q, eff_idx;
  logic                   started_q, last_q, have_addr_q, open_q;
  logic [31:0]            err_acc_q, err_n, data_q;
  sc_mode_e               mode_q, dec_mode;
  logic                   dec_unknown, dec_malformed;
  logic [AddrW-1:0]       acc_addr_q, cur_addr;
  logic                   accept, frame_live, hdr_load, burst_step, is_rd, is_burst;

  sc_cmd_decode u_dec (
    .word_i      (in_data_i),
    .mode_o      (dec_mode),
    .unknown_o   (dec_unknown),
    .malformed_o (dec_malformed)
  );

  assign in_ready_o = (state_q == ST_HDR) || (state_q == ST_HOLD) || (state_q == ST_PAY);
  assign accept     = in_valid_i && in_ready_o;
  assign eff_idx    = in_sof_i ? '0 : idx_q;
  assign frame_live = in_sof_i || started_q;
  assign is_rd      = (mode_q == MODE_BRD) || (mode_q == MODE_LIST);
  assign is_burst   = (mode_q == MODE_BWR) || (mode_q == MODE_BRD);
  assign hdr_load   = (state_q == ST_HDR) && accept && frame_live && (eff_idx == IdxLast);
  assign burst_step = (state_q == ST_PAY) && accept && is_burst;

  sc_addr_gen #(.AddrW(AddrW)) u_addr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (hdr_load),
    .load_val_i (in_data_i[AddrW-1:0]),
    .step_i     (burst_step),
    .addr_o     (cur_addr)
  );

  // header error flags accumulate word by word
  always_comb begin
    err_n = (eff_idx == '0) ? '0 : err_acc_q;
    if (eff_idx == '0 && !in_data_i[31]) err_n[ERR_ID] = 1'b1;
    if (eff_idx == IdxCmd) begin
      if (dec_unknown)   err_n[ERR_UNKNOWN]   = 1'b1;
      if (dec_malformed) err_n[ERR_MALFORMED] = 1'b1;
    end
    if (in_eof_i && eff_idx != IdxLast) err_n[ERR_SHORT] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_HDR;
      hdr_q       <= '0;
      idx_q       <= '0;
      started_q   <= 1'b0;
      last_q      <= 1'b0;
      have_addr_q <= 1'b0;
      open_q      <= 1'b0;
      err_acc_q   <= '0;
      data_q      <= '0;
      mode_q      <= MODE_PAIRS;
      acc_addr_q  <= '0;
    end else begin
      unique case (state_q)
        ST_HDR: if (accept && frame_live) begin
          hdr_q[eff_idx] <= in_data_i;
          err_acc_q      <= err_n;
          if (eff_idx == IdxCmd) mode_q <= dec_mode;
          if (in_eof_i || eff_idx == IdxLast) begin
            started_q <= 1'b0;
            idx_q     <= '0;
            if (err_n != '0) begin
              open_q  <= 1'b0;
              if (!in_eof_i)           state_q <= ST_HOLD;
              else if (err_reply_en_i) state_q <= ST_FAIL;
            end else begin
              state_q     <= ST_ECHO;
              last_q      <= in_eof_i;
              have_addr_q <= 1'b0;
            end
          end else begin
            idx_q     <= eff_idx + 1'b1;
            started_q <= 1'b1;
          end
        end
        ST_HOLD: if (accept && in_eof_i) state_q <= err_reply_en_i ? ST_FAIL : ST_HDR;
        ST_ECHO: begin
          idx_q <= idx_q + 1'b1;
          if (idx_q == IdxLast) state_q <= last_q ? ST_HDR : ST_PAY;
        end
        ST_PAY: if (accept) begin
          last_q <= in_eof_i;
          unique case (mode_q)
            MODE_PAIRS: if (!have_addr_q) begin
              acc_addr_q  <= in_data_i[AddrW-1:0];
              have_addr_q <= 1'b1;
              if (in_eof_i) begin
                err_acc_q <= 32'd1 << ERR_MALFORMED;
                open_q    <= 1'b1;
                state_q   <= ST_FAIL;
              end
            end else begin
              data_q      <= in_data_i;
              have_addr_q <= 1'b0;
              state_q     <= ST_STRB;
            end
            MODE_BWR: begin
              acc_addr_q <= cur_addr;
              data_q     <= in_data_i;
              state_q    <= ST_STRB;
            end
            MODE_BRD: begin
              acc_addr_q <= cur_addr;
              state_q    <= ST_STRB;
            end
            default: begin
              acc_addr_q <= in_data_i[AddrW-1:0];
              state_q    <= ST_STRB;
            end
          endcase
        end
        ST_STRB: state_q <= ST_ERRW;
        ST_ERRW: begin
          if (is_rd) data_q <= reg_rdata_i;
          state_q <= ST_DATW;
        end
        ST_DATW: state_q <= last_q ? ST_HDR : ST_PAY;
        default: state_q <= ST_HDR;
      endcase
    end
  end

  assign reg_addr_o  = acc_addr_q;
  assign reg_wdata_o = data_q;
  assign reg_we_o    = (state_q == ST_STRB) && !is_rd;
  assign reg_re_o    = (state_q == ST_STRB) && is_rd;

  always_comb begin
    out_valid_o = 1'b0;
    out_sof_o   = 1'b0;
    out_eof_o   = 1'b0;
    out_data_o  = '0;
    unique case (state_q)
      ST_ECHO: begin
        out_valid_o = 1'b1;
        out_sof_o   = (idx_q == '0);
        out_eof_o   = (idx_q == IdxLast) && last_q;
        out_data_o  = (idx_q == '0) ? {1'b0, hdr_q[0][30:0]} : hdr_q[idx_q];
      end
      ST_ERRW: begin
        out_valid_o = 1'b1;
        out_data_o  = reg_err_i;
      end
      ST_DATW: begin
        out_valid_o = 1'b1;
        out_eof_o   = last_q;
        out_data_o  = data_q;
      end
      ST_FAIL: begin
        out_valid_o = 1'b1;
        out_sof_o   = !open_q;
        out_eof_o   = 1'b1;
        out_data_o  = err_acc_q;
      end
      default: ;
    endcase
  end

  // R8: strobes are exclusive and one cycle wide
  a_r8_strobe_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reg_we_o && reg_re_o));
  a_r8_strobe_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_o || reg_re_o) |=> !(reg_we_o || reg_re_o));
  // R7: error word follows each strobe; no input taken while replying
  a_r7_err_after_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_o || reg_re_o) |=> (out_valid_o && !out_sof_o && !out_eof_o));
  a_r7_no_accept_while_reply: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> !in_ready_o);
  // R2: reply id has bit 31 cleared
  a_r2_reply_id_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_sof_o && !out_eof_o) |-> !out_data_o[31]);
  // R12: single-word error reply stands alone
  a_r12_single_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_sof_o && out_eof_o) |=> !out_valid_o);
endmodule

// File: tb/sc_req_decoder_bench.sv
`timescale 1ns/1ps
module sc_req_decoder_bench;
  localparam int AW = 4;
  localparam logic [31:0] B27 = 32'h0800_0000, B26 = 32'h0400_0000;
  localparam logic [31:0] B19 = 32'h0008_0000, B18 = 32'h0004_0000;

  logic clk = 1'b0, rst_n = 1'b0, err_en = 1'b1;
  logic in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
  logic [31:0] in_data = '0;
  logic in_ready, we, re, out_valid, out_sof, out_eof;
  logic [AW-1:0] addr;
  logic [31:0] wdata, out_data;
  logic [31:0] rdata_q, rerr_q;
  logic [31:0] bus_mem [16];

  always #4 clk = ~clk;

  sc_req_decoder #(.AddrW(AW)) u_sc_req_decoder (
    .clk_i(clk), .rst_ni(rst_n), .err_reply_en_i(err_en),
    .in_valid_i(in_valid), .in_sof_i(in_sof), .in_eof_i(in_eof), .in_data_i(in_data),
    .in_ready_o(in_ready), .reg_addr_o(addr), .reg_wdata_o(wdata),
    .reg_we_o(we), .reg_re_o(re), .reg_rdata_i(rdata_q), .reg_err_i(rerr_q),
    .out_valid_o(out_valid), .out_sof_o(out_sof), .out_eof_o(out_eof), .out_data_o(out_data)
  );

  function automatic logic [31:0] errfn(input logic [AW-1:0] a);
    return a[0] ? {24'h0, 4'hE, a} : 32'h0;
  endfunction
  function automatic logic [31:0] init_val(input int i);
    return 32'hA500_0000 + i * 32'h0001_0001;
  endfunction

  // register bus model
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) bus_mem[i] <= init_val(i);
      rdata_q <= '0;
      rerr_q  <= '0;
    end else begin
      if (we) bus_mem[addr] <= wdata;
      if (re) rdata_q <= bus_mem[addr];
      if (we || re) rerr_q <= errfn(addr);
    end
  end

  // reply collector and strobe counter
  logic [33:0] got [1024];
  int got_n = 0, strb_n = 0;
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (got_n < 1024) got[got_n] = {out_sof, out_eof, out_data};
      got_n++;
    end
    if (rst_n && (we || re)) strb_n++;
  end

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      checks++; fails++;
      $display("FAIL watchdog: got %0d cycles exp fewer", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  logic [31:0] frm [32];
  int frm_n;
  logic [31:0] exp_mem [16];
  logic [33:0] expw [64];
  int exp_n, exp_acc;

  task automatic push(input logic [31:0] d, input bit s, input bit e);
    expw[exp_n] = {s, e, d};
    exp_n++;
  endtask

  function automatic logic [31:0] decerr(input logic [31:0] w);
    logic [31:0] e;
    e = '0;
    if (!((w[31:24] == 8'hAA || w[31:24] == 8'hBB) && (w[23:16] == 8'hAA || w[23:16] == 8'hBB)))
      e |= B19;
    if (w[15:0] != 16'hFFFF) e |= B18;
    return e;
  endfunction

  task automatic model(input bit en);
    logic [31:0] e;
    logic [AW-1:0] a, ad;
    bit last;
    int k;
    exp_n = 0; exp_acc = 0; e = '0;
    if (!frm[0][31]) e |= B26;
    if (frm_n >= 3) e |= decerr(frm[2]);
    if (frm_n < 4) e |= B27;
    if (e != 0) begin
      if (en) push(e, 1, 1);
      return;
    end
    push({1'b0, frm[0][30:0]}, 1, 0);
    push(frm[1], 0, 0);
    push(frm[2], 0, 0);
    push(frm[3], 0, frm_n == 4);
    a = frm[3][AW-1:0];
    if (frm[2][31:16] == 16'hAAAA) begin
      k = 4;
      while (k < frm_n) begin
        if (k + 1 >= frm_n) begin push(B18, 0, 1); break; end
        ad = frm[k][AW-1:0];
        push(errfn(ad), 0, 0); push(frm[k+1], 0, k + 1 == frm_n - 1);
        exp_mem[ad] = frm[k+1]; exp_acc++;
        k += 2;
      end
    end else begin
      for (int j = 4; j < frm_n; j++) begin
        last = (j == frm_n - 1);
        if (frm[2][31:16] == 16'hAABB) begin
          push(errfn(a), 0, 0); push(frm[j], 0, last); exp_mem[a] = frm[j]; a++;
        end else if (frm[2][31:16] == 16'hBBBB) begin
          push(errfn(a), 0, 0); push(exp_mem[a], 0, last); a++;
        end else begin
          ad = frm[j][AW-1:0];
          push(errfn(ad), 0, 0); push(exp_mem[ad], 0, last);
        end
        exp_acc++;
      end
    end
  endtask

  task automatic send(input bit gaps);
    for (int i = 0; i < frm_n; i++) begin
      if (gaps && ($urandom % 3) == 0) begin
        in_valid = 1'b0;
        @(negedge clk);
      end
      in_valid = 1'b1; in_sof = (i == 0); in_eof = (i == frm_n - 1); in_data = frm[i];
      while (!in_ready) @(negedge clk);
      @(negedge clk);
    end
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
  endtask

  task automatic run(input string tag, input bit en, input bit gaps);
    int base, sbase;
    err_en = en;
    base = got_n; sbase = strb_n;
    model(en);
    send(gaps);
    repeat (14) @(negedge clk);
    check({tag, " reply length"}, 64'(got_n - base), 64'(exp_n));
    check("R8 strobe count", 64'(strb_n - sbase), 64'(exp_acc));
    for (int i = 0; i < exp_n && i < got_n - base; i++)
      check({tag, " reply word"}, 64'(got[base + i]), 64'(expw[i]));
  endtask

  task automatic hdr(input logic [31:0] id, input logic [31:0] c1, input logic [31:0] c2);
    frm[0] = id; frm[1] = 32'h0000_0005; frm[2] = c1; frm[3] = c2; frm_n = 4;
  endtask
  task automatic add(input logic [31:0] w);
    frm[frm_n] = w; frm_n++;
  endtask

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 16; i++) exp_mem[i] = init_val(i);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset outputs", {60'h0, out_valid, we, re, in_ready}, 64'h1);

    // R3 paired writes
    hdr(32'h8000_0001, 32'hAAAA_FFFF, 32'h0);
    add(32'd3); add(32'h1111_0000); add(32'd4); add(32'h2222_0000);
    run("R3 pairs", 1, 0);
    // R4 burst write wrapping at the top
    hdr(32'h8000_0002, 32'hAABB_FFFF, 32'd14);
    for (int i = 0; i < 4; i++) add(32'hB000_0000 + i);
    run("R4 burst write", 1, 0);
    // R5 burst read wrapping
    hdr(32'h8123_4567, 32'hBBBB_FFFF, 32'd13);
    for (int i = 0; i < 4; i++) add(32'hDEAD_0000);
    run("R5 burst read", 1, 0);
    // R6 list read
    hdr(32'hFFFF_FFFF, 32'hBBAA_FFFF, 32'h0);
    add(32'd3); add(32'hFFFF_FF0E); add(32'd1);
    run("R6 list read", 1, 0);
    // R7 no payload: eof on fourth header word
    hdr(32'h8000_0010, 32'hAAAA_FFFF, 32'h0);
    run("R7 empty payload", 1, 0);
    // R9 id bit clear, reply enabled / disabled
    hdr(32'h0000_0011, 32'hAAAA_FFFF, 32'h0);
    add(32'd2); add(32'h5555_5555);
    run("R9 bad id", 1, 0);
    run("R12 reply disabled", 0, 0);
    // R10 short frame
    hdr(32'h8000_0012, 32'hAAAA_FFFF, 32'h0);
    frm_n = 3;
    run("R10 short", 1, 0);
    frm_n = 2;
    run("R10 short two", 1, 0);
    // R11 unknown command and bad length field
    hdr(32'h8000_0013, 32'hCCAA_FFFF, 32'h0);
    add(32'd1);
    run("R11 unknown", 1, 0);
    hdr(32'h8000_0014, 32'hBBBB_0010, 32'h0);
    add(32'd1);
    run("R11 malformed", 1, 0);
    // R13 odd paired payload, then read back the unpaired address
    hdr(32'h8000_0015, 32'hAAAA_FFFF, 32'h0);
    add(32'd2); add(32'h3333_3333); add(32'd7);
    run("R13 odd pairs", 1, 0);
    hdr(32'h8000_0016, 32'hBBAA_FFFF, 32'h0);
    add(32'd7); add(32'd2);
    run("R13 readback", 1, 0);

    // random mix
    for (int f = 0; f < 40; f++) begin
      int m, len;
      string tag;
      m = $urandom % 4;
      len = (m == 0) ? 2 * ($urandom % 4) : $urandom % 7;
      unique case (m)
        0: begin hdr(32'h8000_0000 | $urandom, 32'hAAAA_FFFF, $urandom); tag = "R3 rand"; end
        1: begin hdr(32'h8000_0000 | $urandom, 32'hAABB_FFFF, $urandom); tag = "R4 rand"; end
        2: begin hdr(32'h8000_0000 | $urandom, 32'hBBBB_FFFF, $urandom); tag = "R5 rand"; end
        default: begin hdr(32'h8000_0000 | $urandom, 32'hBBAA_FFFF, $urandom); tag = "R6 rand"; end
      endcase
      for (int i = 0; i < len; i++) add($urandom);
      if (($urandom % 6) == 0) begin
        frm[0][31] = 1'b0;
        tag = "R9 rand";
      end
      run(tag, ($urandom % 4) != 0, 1);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule